// File: doc/BRIEF.md
# Trap entry controller

This block decides which pending event a processor core enters next, and computes every state change needed to start its handler. It handles four event classes: a reset request (hardware or software), a debug break, a program or software exception, and a leveled external interrupt. Each cycle it samples the core's current PC, the PC of the previous instruction packet, the status fields (supervisor flag, trap-enable flag, priority interrupt level) and the trap base field. One clock edge later it presents write strobes and values for the status fields, the break-status copy, the two saved-PC registers, the trap type field and the PC.

External requests arrive as one-cycle raise pulses, one bit per level from 1 to 15. They are held in a pending set inside the block until they are accepted. Only the highest pending level is considered for acceptance. It is taken when traps are enabled and its level is not below the current mask, and level 15 ignores the mask. A program or software exception taken while traps are disabled still performs the full entry update, and it also raises a halt indication. The core then stops with the handler address as its resume PC.

Top module: `trap_entry`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it rises with no request, `entered`, every write strobe, `halt` and `cause` are 0, and `extPending` is empty.
- R2: A reset request is entered with `cause` 1 when `hwRstReq` is set (this wins over `swRstReq`), or with `cause` 2 for `swRstReq` alone. The only other strobe raised is `pcWe`, with `pcVal` = 0xFF000000 when `hsr0Sa` is 1 and 0 otherwise.
- R3: A break (`cause` 3) raises `bpsrWe`, with `bpsrBs` taken from `psrS` and `bpsrBet` taken from `psrEt`. It also raises `bpcsrWe` with `bpcsrVal` = `curPc`, and sets `tbrTt` to 0xFF. Neither `pcsrWe` nor `psrPsWe` is raised.
- R4: The handler PC is formed from the trap base field, the type value and four zero bits, with the type in bits [11:4] and the base in bits [31:12]. For example, base 0x40000 with type 0x23 gives 0x40000230. `tbrWe` and `pcWe` carry it.
- R5: A program or software exception (`cause` 4) raises `psrPsWe` with `psrPsNext` = `psrS`, raises `pcsrWe`, and writes `excTt` into `tbrTt`. `pcsrVal` is `prevPc` when `excPrecise` is 1 and `curPc` otherwise.
- R6: `halt` is 1 exactly when an exception is entered while `psrEt` is 0. The full entry update and handler PC are still produced.
- R7: When an external level L (1..15) is accepted, it is entered with `cause` 5 and `tbrTt` = 0x10 + L, and `pcsrVal` = `curPc`. Its pending bit clears at the same edge. Level 15 is accepted even when `psrPil` is 15.
- R8: An external request whose level is below `psrPil`, or any request while `psrEt` is 0, causes no entry, and its bit stays set in `extPending`.
- R9: Among several pending levels, only the highest is considered. When it is accepted, the lower levels stay pending.
- R10: Simultaneous events are taken in the order reset, break, exception, external, one per cycle. An external request passed over stays pending.
- R11: `entered` goes high for one cycle, one clock edge after the event is sampled, and falls when no event follows.
- R12: Every write of a saved-PC register (`pcsrWe` or `bpcsrWe`) comes with `psrWe`, `psrSNext` = 1 and `psrEtNext` = 0 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| curPc | input | 32 | PC of the current instruction |
| prevPc | input | 32 | PC of the previous instruction packet |
| tbrBase | input | 20 | Trap base field (handler address bits 31:12) |
| psrS | input | 1 | Current supervisor flag |
| psrEt | input | 1 | Current trap-enable flag |
| psrPil | input | 4 | Current priority interrupt level |
| hsr0Sa | input | 1 | Selects the high reset vector |
| hwRstReq | input | 1 | Hardware reset request |
| swRstReq | input | 1 | Software reset request |
| brkReq | input | 1 | Break event |
| excReq | input | 1 | Program or software exception |
| excPrecise | input | 1 | Exception is precise |
| excTt | input | 8 | Handler type of the exception |
| extRaise | input | 15 | One-cycle raise pulse per external level 15..1 |
| entered | output | 1 | Handler entry pulse |
| cause | output | 3 | Entered event: 0 none, 1 hw reset, 2 sw reset, 3 break, 4 exception, 5 external |
| psrWe | output | 1 | Write supervisor and trap-enable flags |
| psrSNext | output | 1 | Next supervisor flag |
| psrEtNext | output | 1 | Next trap-enable flag |
| psrPsWe | output | 1 | Write previous-supervisor flag |
| psrPsNext | output | 1 | Value for previous-supervisor flag |
| bpsrWe | output | 1 | Write break status copy |
| bpsrBs | output | 1 | Saved supervisor flag for break |
| bpsrBet | output | 1 | Saved trap-enable flag for break |
| pcsrWe | output | 1 | Write trap saved-PC register |
| pcsrVal | output | 32 | Trap saved-PC value |
| bpcsrWe | output | 1 | Write break saved-PC register |
| bpcsrVal | output | 32 | Break saved-PC value |
| tbrWe | output | 1 | Write trap type field |
| tbrTt | output | 8 | Trap type value |
| pcWe | output | 1 | Load new PC |
| pcVal | output | 32 | New PC |
| halt | output | 1 | Stop the core after entry |
| extPending | output | 15 | Pending external levels 15..1 |

## Verification
A break and an external interrupt can both be ready in the same cycle. This is provoked by leaving a low level pending, dropping the mask to zero and asserting the break on that same cycle. The entered cause must be the break, the level must still be pending afterwards, and it must be entered on the following cycle with its own type value. A reset arriving together with a break, and an exception arriving together with a break, are judged the same way by the vector table.

// File: rtl/trap_pkg.sv
package trap_pkg;

  typedef enum logic [2:0] {
    CS_NONE = 3'd0,
    CS_HRST = 3'd1,
    CS_SRST = 3'd2,
    CS_BRK  = 3'd3,
    CS_EXC  = 3'd4,
    CS_EXT  = 3'd5
  } cause_e;

  // control-to-datapath strobe bundle
  typedef struct packed {
    cause_e cause;
    logic   take;
    logic   psrUpd;
    logic   psUpd;
    logic   bpsrUpd;
    logic   pcsrUpd;
    logic   bpcsrUpd;
    logic   tbrUpd;
    logic   haltReq;
    logic   ackExt;
  } ctl_t;

endpackage

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
#(
  parameter int LVLW    = 4,
  parameter int TOP_LVL = 15
) (
  input  logic            hwRstReq,
  input  logic            swRstReq,
  input  logic            brkReq,
  input  logic            excReq,
  input  logic            psrEt,
  input  logic [LVLW-1:0] psrPil,
  input  logic            pendAny,
  input  logic [LVLW-1:0] topLvl,
  output ctl_t            ctl
);

  localparam logic [LVLW-1:0] TopCode = LVLW'(TOP_LVL);

  logic extOk;

  // highest pending level passes the mask, or is the unmaskable level
  assign extOk = pendAny && psrEt && ((topLvl >= psrPil) || (topLvl == TopCode));

  always_comb begin
    ctl       = '0;
    ctl.cause = CS_NONE;
    if (hwRstReq) begin
      ctl.cause = CS_HRST;
    end else if (swRstReq) begin
      ctl.cause = CS_SRST;
    end else if (brkReq) begin
      ctl.cause    = CS_BRK;
      ctl.psrUpd   = 1'b1;
      ctl.bpsrUpd  = 1'b1;
      ctl.bpcsrUpd = 1'b1;
      ctl.tbrUpd   = 1'b1;
    end else if (excReq) begin
      ctl.cause   = CS_EXC;
      ctl.psrUpd  = 1'b1;
      ctl.psUpd   = 1'b1;
      ctl.pcsrUpd = 1'b1;
      ctl.tbrUpd  = 1'b1;
      ctl.haltReq = !psrEt;
    end else if (extOk) begin
      ctl.cause   = CS_EXT;
      ctl.psrUpd  = 1'b1;
      ctl.psUpd   = 1'b1;
      ctl.pcsrUpd = 1'b1;
      ctl.tbrUpd  = 1'b1;
      ctl.ackExt  = 1'b1;
    end
    ctl.take = (ctl.cause != CS_NONE);
  end

endmodule

// File: rtl/trap_dp.sv
module trap_dp
  import trap_pkg::*;
#(
  parameter int              AW          = 32,
  parameter int              NLVL        = 16,
  parameter int              LVLW        = 4,
  parameter int              TTW         = 8,
  parameter int              SLOT        = 4,
  parameter logic [TTW-1:0]  BRK_TT      = 8'hFF,
  parameter logic [TTW-1:0]  EXT_TT_BASE = 8'h10,
  parameter logic [AW-1:0]   RST_VEC     = 32'hFF00_0000
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctl_t                     ctl,
  input  logic [AW-1:0]            curPc,
  input  logic [AW-1:0]            prevPc,
  input  logic [AW-SLOT-TTW-1:0]   tbrBase,
  input  logic                     psrS,
  input  logic                     psrEt,
  input  logic                     hsr0Sa,
  input  logic                     excPrecise,
  input  logic [TTW-1:0]           excTt,
  input  logic [NLVL-1:1]          extRaise,
  output logic                     pendAny,
  output logic [LVLW-1:0]          topLvl,
  output logic                     entered,
  output logic [2:0]               cause,
  output logic                     psrWe,
  output logic                     psrSNext,
  output logic                     psrEtNext,
  output logic                     psrPsWe,
  output logic                     psrPsNext,
  output logic                     bpsrWe,
  output logic                     bpsrBs,
  output logic                     bpsrBet,
  output logic                     pcsrWe,
  output logic [AW-1:0]            pcsrVal,
  output logic                     bpcsrWe,
  output logic [AW-1:0]            bpcsrVal,
  output logic                     tbrWe,
  output logic [TTW-1:0]           tbrTt,
  output logic                     pcWe,
  output logic [AW-1:0]            pcVal,
  output logic                     halt,
  output logic [NLVL-1:1]          extPending
);

  logic [NLVL-1:1] pendQ;
  logic [TTW-1:0]  ttNext;
  logic [AW-1:0]   handlerPc;
  logic [AW-1:0]   rstPc;
  logic [AW-1:0]   pcsrNext;

  // one pending flop per external level; raise wins over a same-edge clear
  for (genvar g = 1; g < NLVL; g++) begin : g_lvl
    always_ff @(posedge clk) begin
      if (!rstN) pendQ[g] <= 1'b0;
      else       pendQ[g] <= (pendQ[g] & ~(ctl.ackExt && (topLvl == LVLW'(g)))) | extRaise[g];
    end
  end

  always_comb begin
    topLvl = '0;
    for (int i = 1; i < NLVL; i++) begin
      if (pendQ[i]) topLvl = LVLW'(i);
    end
  end

  assign pendAny    = |pendQ;
  assign extPending = pendQ;

  always_comb begin
    case (ctl.cause)
      CS_BRK:  ttNext = BRK_TT;
      CS_EXC:  ttNext = excTt;
      default: ttNext = EXT_TT_BASE + TTW'(topLvl);
    endcase
  end

  assign handlerPc = {tbrBase, ttNext, {SLOT{1'b0}}};
  assign rstPc     = hsr0Sa ? RST_VEC : '0;
  assign pcsrNext  = ((ctl.cause == CS_EXC) && excPrecise) ? prevPc : curPc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entered   <= 1'b0;
      cause     <= 3'd0;
      psrWe     <= 1'b0;
      psrSNext  <= 1'b0;
      psrEtNext <= 1'b0;
      psrPsWe   <= 1'b0;
      psrPsNext <= 1'b0;
      bpsrWe    <= 1'b0;
      bpsrBs    <= 1'b0;
      bpsrBet   <= 1'b0;
      pcsrWe    <= 1'b0;
      pcsrVal   <= '0;
      bpcsrWe   <= 1'b0;
      bpcsrVal  <= '0;
      tbrWe     <= 1'b0;
      tbrTt     <= '0;
      pcWe      <= 1'b0;
      pcVal     <= '0;
      halt      <= 1'b0;
    end else begin
      entered   <= ctl.take;
      cause     <= ctl.cause;
      psrWe     <= ctl.psrUpd;
      psrSNext  <= ctl.psrUpd ? 1'b1 : psrS;
      psrEtNext <= ctl.psrUpd ? 1'b0 : psrEt;
      psrPsWe   <= ctl.psUpd;
      psrPsNext <= psrS;
      bpsrWe    <= ctl.bpsrUpd;
      bpsrBs    <= psrS;
      bpsrBet   <= psrEt;
      pcsrWe    <= ctl.pcsrUpd;
      pcsrVal   <= pcsrNext;
      bpcsrWe   <= ctl.bpcsrUpd;
      bpcsrVal  <= curPc;
      tbrWe     <= ctl.tbrUpd;
      tbrTt     <= ttNext;
      pcWe      <= ctl.take;
      pcVal     <= ((ctl.cause == CS_HRST) || (ctl.cause == CS_SRST)) ? rstPc : handlerPc;
      halt      <= ctl.haltReq;
    end
  end

endmodule

// File: rtl/trap_entry.sv
module trap_entry
  import trap_pkg::*;
#(
  parameter int             AW          = 32,
  parameter int             NLVL        = 16,
  parameter int             TTW         = 8,
  parameter int             SLOT        = 4,
  parameter logic [TTW-1:0] BRK_TT      = 8'hFF,
  parameter logic [TTW-1:0] EXT_TT_BASE = 8'h10,
  parameter logic [AW-1:0]  RST_VEC     = 32'hFF00_0000,
  localparam int            LVLW        = $clog2(NLVL),
  localparam int            BASE_W      = AW - SLOT - TTW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [AW-1:0]     curPc,
  input  logic [AW-1:0]     prevPc,
  input  logic [BASE_W-1:0] tbrBase,
  input  logic              psrS,
  input  logic              psrEt,
  input  logic [LVLW-1:0]   psrPil,
  input  logic              hsr0Sa,
  input  logic              hwRstReq,
  input  logic              swRstReq,
  input  logic              brkReq,
  input  logic              excReq,
  input  logic              excPrecise,
  input  logic [TTW-1:0]    excTt,
  input  logic [NLVL-1:1]   extRaise,
  output logic              entered,
  output logic [2:0]        cause,
  output logic              psrWe,
  output logic              psrSNext,
  output logic              psrEtNext,
  output logic              psrPsWe,
  output logic              psrPsNext,
  output logic              bpsrWe,
  output logic              bpsrBs,
  output logic              bpsrBet,
  output logic              pcsrWe,
  output logic [AW-1:0]     pcsrVal,
  output logic              bpcsrWe,
  output logic [AW-1:0]     bpcsrVal,
  output logic              tbrWe,
  output logic [TTW-1:0]    tbrTt,
  output logic              pcWe,
  output logic [AW-1:0]     pcVal,
  output logic              halt,
  output logic [NLVL-1:1]   extPending
);

  ctl_t            ctl;
  logic            pendAny;
  logic [LVLW-1:0] topLvl;

  trap_ctrl #(.LVLW(LVLW), .TOP_LVL(NLVL - 1)) u_ctrl (
    .hwRstReq(hwRstReq), .swRstReq(swRstReq), .brkReq(brkReq), .excReq(excReq),
    .psrEt(psrEt), .psrPil(psrPil), .pendAny(pendAny), .topLvl(topLvl), .ctl(ctl)
  );

  trap_dp #(
    .AW(AW), .NLVL(NLVL), .LVLW(LVLW), .TTW(TTW), .SLOT(SLOT),
    .BRK_TT(BRK_TT), .EXT_TT_BASE(EXT_TT_BASE), .RST_VEC(RST_VEC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .curPc(curPc), .prevPc(prevPc),
    .tbrBase(tbrBase), .psrS(psrS), .psrEt(psrEt), .hsr0Sa(hsr0Sa),
    .excPrecise(excPrecise), .excTt(excTt), .extRaise(extRaise),
    .pendAny(pendAny), .topLvl(topLvl), .entered(entered), .cause(cause),
    .psrWe(psrWe), .psrSNext(psrSNext), .psrEtNext(psrEtNext),
    .psrPsWe(psrPsWe), .psrPsNext(psrPsNext), .bpsrWe(bpsrWe),
    .bpsrBs(bpsrBs), .bpsrBet(bpsrBet), .pcsrWe(pcsrWe), .pcsrVal(pcsrVal),
    .bpcsrWe(bpcsrWe), .bpcsrVal(bpcsrVal), .tbrWe(tbrWe), .tbrTt(tbrTt),
    .pcWe(pcWe), .pcVal(pcVal), .halt(halt), .extPending(extPending)
  );

endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk
  import trap_pkg::*;
#(
  parameter int             AW      = 32,
  parameter int             NLVL    = 16,
  parameter int             TTW     = 8,
  parameter int             SLOT    = 4,
  parameter logic [TTW-1:0] BRK_TT  = 8'hFF,
  parameter logic [AW-1:0]  RST_VEC = 32'hFF00_0000
) (
  input logic            clk,
  input logic            rstN,
  input logic            entered,
  input logic [2:0]      cause,
  input logic            psrWe,
  input logic            psrSNext,
  input logic            psrEtNext,
  input logic            psrPsWe,
  input logic            bpsrWe,
  input logic            pcsrWe,
  input logic            bpcsrWe,
  input logic            tbrWe,
  input logic [TTW-1:0]  tbrTt,
  input logic            pcWe,
  input logic [AW-1:0]   pcVal,
  input logic            halt,
  input logic [NLVL-1:1] extPending
);

  // R12
  super_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pcsrWe || bpcsrWe) |-> (psrWe && psrSNext && !psrEtNext));

  // R2
  rst_vec_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((cause == CS_HRST) || (cause == CS_SRST)) |->
      (pcWe && !psrWe && !tbrWe && !pcsrWe && !bpcsrWe && ((pcVal == RST_VEC) || (pcVal == '0))));

  // R4
  handler_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    tbrWe |-> ((pcVal[SLOT+TTW-1:SLOT] == tbrTt) && (pcVal[SLOT-1:0] == '0) && pcWe));

  // R3
  brk_split_chk: assert property (@(posedge clk) disable iff (!rstN)
    bpsrWe |-> (!pcsrWe && !psrPsWe && bpcsrWe && (tbrTt == BRK_TT)));

  // R6
  halt_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    halt |-> (entered && (cause == CS_EXC) && pcsrWe));

  // R8
  pend_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(extPending) & ~extPending)) |-> (entered && (cause == CS_EXT)));

  // R11
  one_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    entered |-> (pcWe && $onehot0({bpsrWe, psrPsWe})));

endmodule

bind trap_entry trap_entry_chk #(
  .AW(AW), .NLVL(NLVL), .TTW(TTW), .SLOT(SLOT), .BRK_TT(BRK_TT), .RST_VEC(RST_VEC)
) u_chk (
  .clk(clk), .rstN(rstN), .entered(entered), .cause(cause), .psrWe(psrWe),
  .psrSNext(psrSNext), .psrEtNext(psrEtNext), .psrPsWe(psrPsWe), .bpsrWe(bpsrWe),
  .pcsrWe(pcsrWe), .bpcsrWe(bpcsrWe), .tbrWe(tbrWe), .tbrTt(tbrTt), .pcWe(pcWe),
  .pcVal(pcVal), .halt(halt), .extPending(extPending)
);

// File: tb/sim_trap_entry.sv
module sim_trap_entry;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] CUR_PC  = 32'h1000_0104;
  localparam logic [31:0] PREV_PC = 32'h1000_00F8;

  logic clk = 1'b0;
  logic rstN;
  logic [31:0] curPc, prevPc;
  logic [19:0] tbrBase;
  logic psrS, psrEt, hsr0Sa, hwRstReq, swRstReq, brkReq, excReq, excPrecise;
  logic [3:0] psrPil;
  logic [7:0] excTt;
  logic [15:1] extRaise;
  logic entered, psrWe, psrSNext, psrEtNext, psrPsWe, psrPsNext;
  logic bpsrWe, bpsrBs, bpsrBet, pcsrWe, bpcsrWe, tbrWe, pcWe, halt;
  logic [2:0] cause;
  logic [31:0] pcsrVal, bpcsrVal, pcVal;
  logic [7:0] tbrTt;
  logic [15:1] extPending;

  int nChk = 0;
  int nErr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_entry u0 (
    .clk(clk), .rstN(rstN), .curPc(curPc), .prevPc(prevPc), .tbrBase(tbrBase),
    .psrS(psrS), .psrEt(psrEt), .psrPil(psrPil), .hsr0Sa(hsr0Sa),
    .hwRstReq(hwRstReq), .swRstReq(swRstReq), .brkReq(brkReq), .excReq(excReq),
    .excPrecise(excPrecise), .excTt(excTt), .extRaise(extRaise),
    .entered(entered), .cause(cause), .psrWe(psrWe), .psrSNext(psrSNext),
    .psrEtNext(psrEtNext), .psrPsWe(psrPsWe), .psrPsNext(psrPsNext),
    .bpsrWe(bpsrWe), .bpsrBs(bpsrBs), .bpsrBet(bpsrBet), .pcsrWe(pcsrWe),
    .pcsrVal(pcsrVal), .bpcsrWe(bpcsrWe), .bpcsrVal(bpcsrVal), .tbrWe(tbrWe),
    .tbrTt(tbrTt), .pcWe(pcWe), .pcVal(pcVal), .halt(halt), .extPending(extPending)
  );

  // causes: 1 hw reset, 2 sw reset, 3 break, 4 exception, 5 external
  typedef struct packed {
    logic hw, sw, brk, exc, prc, s, et, sa;
    logic [7:0]  tt;
    logic [2:0]  cs;
    logic        hlt;
    logic [31:0] pc;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,8'h00,3'd1,1'b0,32'hFF00_0000},
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,8'h00,3'd2,1'b0,32'h0000_0000},
    '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,8'h00,3'd1,1'b0,32'h0000_0000},
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,8'h00,3'd3,1'b0,32'h4000_0FF0},
    '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,8'h23,3'd3,1'b0,32'h4000_0FF0},
    '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,8'h23,3'd4,1'b0,32'h4000_0230},
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,8'h07,3'd4,1'b1,32'h4000_0070},
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,8'h07,3'd2,1'b0,32'hFF00_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] lv(input int n);
    return 32'(1) << n;
  endfunction

  function automatic logic [31:0] pend();
    return {16'b0, extPending, 1'b0};
  endfunction

  task automatic raise(input logic [15:1] m);
    extRaise = m;
    step();
    extRaise = '0;
  endtask

  task automatic clearReqs();
    hwRstReq = 0; swRstReq = 0; brkReq = 0; excReq = 0; excPrecise = 0; excTt = '0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    nErr++;
    $display("FAIL R11 watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", nChk, nErr);
    $finish;
  end

  initial begin
    rstN = 0; curPc = CUR_PC; prevPc = PREV_PC; tbrBase = 20'h40000;
    psrS = 0; psrEt = 0; psrPil = '0; hsr0Sa = 0; extRaise = '0;
    clearReqs();
    brkReq = 1; extRaise = 15'h7FFF;   // ignored while in reset
    repeat (3) step();
    chk("R1 entered", 32'(entered), 0);
    chk("R1 pcWe", 32'(pcWe), 0);
    chk("R1 pending", pend(), 0);
    brkReq = 0; extRaise = '0;
    rstN = 1;
    step();
    chk("R1 idle entered", 32'(entered), 0);
    chk("R1 idle cause", 32'(cause), 0);
    chk("R1 idle halt", 32'(halt), 0);

    // table walk: resets, breaks, exceptions and their overlaps
    for (int i = 0; i < 8; i++) begin
      hwRstReq = VEC[i].hw; swRstReq = VEC[i].sw; brkReq = VEC[i].brk;
      excReq = VEC[i].exc; excPrecise = VEC[i].prc; psrS = VEC[i].s;
      psrEt = VEC[i].et; hsr0Sa = VEC[i].sa; excTt = VEC[i].tt;
      step();
      chk("R10 cause", 32'(cause), 32'(VEC[i].cs));
      chk("R11 entered", 32'(entered), 1);
      chk("R4 pcVal", pcVal, VEC[i].pc);
      chk("R6 halt", 32'(halt), 32'(VEC[i].hlt));
      if (VEC[i].cs <= 3'd2) begin
        chk("R2 no psr write", 32'(psrWe), 0);
        chk("R2 no saved pc", 32'({pcsrWe, bpcsrWe}), 0);
      end else begin
        chk("R12 sup set", 32'({psrWe, psrSNext, psrEtNext}), 32'(3'b110));
      end
      if (VEC[i].cs == 3'd3) begin
        chk("R3 bpsr", 32'({bpsrWe, bpsrBs, bpsrBet}), 32'({1'b1, VEC[i].s, VEC[i].et}));
        chk("R3 bpcsr", bpcsrVal, CUR_PC);
        chk("R3 tt", 32'(tbrTt), 32'h0FF);
        chk("R3 no pcsr", 32'({pcsrWe, psrPsWe}), 0);
      end
      if (VEC[i].cs == 3'd4) begin
        chk("R5 ps", 32'({psrPsWe, psrPsNext}), 32'({1'b1, VEC[i].s}));
        chk("R5 pcsr", pcsrVal, VEC[i].prc ? PREV_PC : CUR_PC);
        chk("R5 tt", 32'(tbrTt), 32'(VEC[i].tt));
        chk("R5 no bpsr", 32'(bpsrWe), 0);
      end
      clearReqs();
      step();
      chk("R11 pulse ends", 32'(entered), 0);
    end

    // external: accepted above mask
    psrEt = 1; psrS = 0; psrPil = 4'd5;
    raise(15'(lv(7) >> 1));
    chk("R11 not yet", 32'(entered), 0);
    step();
    chk("R7 cause", 32'(cause), 5);
    chk("R7 tt", 32'(tbrTt), 32'h17);
    chk("R7 pc", pcVal, 32'h4000_0170);
    chk("R7 pcsr", pcsrVal, CUR_PC);
    chk("R7 cleared", pend(), 0);

    // external: masked by level, then by disabled traps, then taken
    psrPil = 4'd9;
    raise(15'(lv(4) >> 1));
    step();
    chk("R8 masked", 32'(entered), 0);
    chk("R8 kept", pend(), lv(4));
    psrEt = 0; psrPil = 4'd3;
    step();
    chk("R8 et off", 32'(entered), 0);
    chk("R8 still kept", pend(), lv(4));
    psrEt = 1;
    step();
    chk("R7 late tt", 32'(tbrTt), 32'h14);
    chk("R7 late clear", pend(), 0);

    // highest of several pending levels
    psrPil = 4'd5;
    raise(15'((lv(6) | lv(3)) >> 1));
    step();
    chk("R9 top taken", 32'(tbrTt), 32'h16);
    chk("R9 lower kept", pend(), lv(3));
    step();
    chk("R9 lower masked", 32'(entered), 0);

    // break and external in the same cycle
    psrPil = 4'd0; brkReq = 1;
    step();
    chk("R10 break first", 32'(cause), 3);
    chk("R10 ext waits", pend(), lv(3));
    brkReq = 0;
    step();
    chk("R10 ext next", 32'(cause), 5);
    chk("R10 ext tt", 32'(tbrTt), 32'h13);

    // level 15 at the highest mask; level 14 held back
    psrPil = 4'd15;
    raise(15'((lv(15) | lv(14)) >> 1));
    step();
    chk("R7 level15 tt", 32'(tbrTt), 32'h1F);
    chk("R8 level14 kept", pend(), lv(14));
    step();
    chk("R8 level14 masked", 32'(entered), 0);

    $display("CHECKS %0d ERRORS %0d", nChk, nErr);
    $finish;
  end

endmodule